// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block gathers interrupt sources for a small 8-bit processor core and turns them into a single request with a vector. Three external pins are synchronized and watched for edges. One pin is watched for both polarities and feeds two separate request lines. Two internal timer pulses are captured directly. Each event latches one of six request flags. The flags always record events, whether or not they are enabled, so software can poll them.

A mask register holds one enable bit per request and a global enable bit. A programmable priority code picks the order in which pending, enabled requests compete. For the winner, the block drives the request line, the winner's index and the pair of program-memory byte addresses that hold its service routine's 16-bit start address. When the core acknowledges, the block clears the granted flag and the global enable. Software must set the global enable again before the next request can be taken.

Registers are accessed over a plain address, write-data and write-enable bus. Read data is combinational from the address.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, the request flags, the mask register and the priority code read as zero, and `irq_req_o` is low.
- R2: A falling edge on `pin_b_i` sets flag 0, on `pin_c_i` sets flag 1 and on `pin_a_i` sets flag 2. A pin change applied before clock edge k shows in the flag register after edge k+2.
- R3: A rising edge on `pin_b_i` sets flag 3. A falling edge on that pin leaves flag 3 clear.
- R4: A one-cycle pulse on `tmr0_pulse_i` sets flag 4, and one on `tmr1_pulse_i` sets flag 5. The flag is set at the same clock edge that samples the pulse.
- R5: Flags latch events while masked. Reading address 0 returns the flags in bits [5:0] and zero in bits [7:6].
- R6: Address 1 is the mask register. Bits [5:0] enable the matching flags, bit 7 is the global enable, and bit 6 is stored and read back. `irq_req_o` is high only when some flag and its enable bit are both set and the global enable is set.
- R7: Address 2 holds a 3-bit priority code in bits [2:0]. Code c from 0 to 5 ranks flag c highest, then c+1 and upward, wrapping after 5. Codes 6 and 7 rank flag 0 highest, ascending.
- R8: While `irq_req_o` is high, `irq_id_o` is the winning index n, `vec_lo_o` equals 2n and `vec_hi_o` equals 2n+1.
- R9: `irq_ack_i` sampled high while `irq_req_o` is high clears the granted flag and the global enable, and leaves the other flags unchanged.
- R10: If a source event for the granted flag arrives in the same cycle as its acknowledge, the flag stays set.
- R11: A write to address 0 loads the flags from bits [5:0]. Writing 0 clears a flag and writing 1 sets it.
- R12: `irq_ack_i` sampled while `irq_req_o` is low changes no flag and no mask bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_a_i | input | 1 | External pin A, falling edge to flag 2 |
| pin_b_i | input | 1 | External pin B, falling edge to flag 0, rising edge to flag 3 |
| pin_c_i | input | 1 | External pin C, falling edge to flag 1 |
| tmr0_pulse_i | input | 1 | Timer 0 event pulse, to flag 4 |
| tmr1_pulse_i | input | 1 | Timer 1 event pulse, to flag 5 |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_we_i | input | 1 | Write enable |
| bus_rdata_o | output | 8 | Read data for the addressed register |
| irq_ack_i | input | 1 | Core acknowledge of the current request |
| irq_req_o | output | 1 | Interrupt request to the core |
| irq_id_o | output | 3 | Index of the winning request |
| vec_lo_o | output | 8 | Address of the vector's first byte |
| vec_hi_o | output | 8 | Address of the vector's second byte |

## Verification
The bench drives pin B in both directions. A design that swapped or merged the two polarity lines would set flag 0 on a rise or flag 3 on a fall. Every priority code is tried against a full set of pending flags and against a sparse pair. This exposes an encoder that does not wrap or that misreads the unassigned codes. The bench acknowledges while a timer pulse for the same flag arrives; a controller that lets the clear win would lose that event. It also acknowledges with nothing pending, which catches a design that clears the global enable or a flag without a grant.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_IRQ  = 6;
  localparam int IRQ_IDW  = $clog2(NUM_IRQ);
  localparam int NUM_PINS = 3;
  localparam int PRIO_W   = 3;

  typedef enum logic [1:0] {
    REG_FLAGS = 2'd0,
    REG_MASK  = 2'd1,
    REG_PRIO  = 2'd2,
    REG_NONE  = 2'd3
  } reg_addr_e;

  localparam int GIE_BIT = 7;
endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
  parameter int N        = 3,
  parameter int STAGES   = 2,
  parameter int RISE_IDX = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pins_i,
  output logic [N-1:0] fall_o,
  output logic         rise_o
);
  logic [N-1:0] sync_q [STAGES];
  logic [N-1:0] prev_q;
  logic [STAGES:0] armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q[0] <= '0;
    else         sync_q[0] <= pins_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[s] <= '0;
      else         sync_q[s] <= sync_q[s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      armed_q <= '0;
    end else begin
      prev_q  <= sync_q[STAGES-1];
      armed_q <= {armed_q[STAGES-1:0], 1'b1};
    end
  end

  // suppress edges until the whole chain holds real pin samples
  assign fall_o = armed_q[STAGES] ? (prev_q & ~sync_q[STAGES-1]) : '0;
  assign rise_o = armed_q[STAGES] & ~prev_q[RISE_IDX] & sync_q[STAGES-1][RISE_IDX];

  // R3
  rise_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
  // R2
  fall_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_o != '0) |=> ((fall_o & $past(fall_o)) == '0));
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
  parameter int N      = 6,
  parameter int IDW    = 3,
  parameter int CODE_W = 3
) (
  input  logic [N-1:0]      pend_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              valid_o,
  output logic [IDW-1:0]    id_o
);
  int unsigned start;

  always_comb begin
    start   = (int'(code_i) < N) ? int'(code_i) : 0;
    valid_o = 1'b0;
    id_o    = '0;
    for (int k = 0; k < N; k++) begin
      int unsigned idx;
      idx = start + k;
      if (idx >= N) idx = idx - N;
      if (!valid_o && pend_i[idx]) begin
        valid_o = 1'b1;
        id_o    = IDW'(idx);
      end
    end
  end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import irq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int VEC_W  = 8,
  parameter int STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pin_a_i,
  input  logic               pin_b_i,
  input  logic               pin_c_i,
  input  logic               tmr0_pulse_i,
  input  logic               tmr1_pulse_i,
  input  logic [1:0]         bus_addr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  input  logic               bus_we_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  input  logic               irq_ack_i,
  output logic               irq_req_o,
  output logic [IRQ_IDW-1:0] irq_id_o,
  output logic [VEC_W-1:0]   vec_lo_o,
  output logic [VEC_W-1:0]   vec_hi_o
);
  logic [NUM_IRQ-1:0]  req_q, req_d, edge_set, ack_clr, pend;
  logic [DATA_W-1:0]   mask_q;
  logic [PRIO_W-1:0]   prio_q;
  logic [NUM_PINS-1:0] pin_fall;
  logic                pin_b_rise, gie, grant, wr_flags, wr_mask, wr_prio;

  // pin order: [0]=A, [1]=B, [2]=C
  irq_edge_detect #(.N(NUM_PINS), .STAGES(STAGES), .RISE_IDX(1)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pins_i ({pin_c_i, pin_b_i, pin_a_i}),
    .fall_o (pin_fall),
    .rise_o (pin_b_rise)
  );

  assign edge_set = {tmr1_pulse_i, tmr0_pulse_i, pin_b_rise,
                     pin_fall[0], pin_fall[2], pin_fall[1]};

  assign wr_flags = bus_we_i && (bus_addr_i == REG_FLAGS);
  assign wr_mask  = bus_we_i && (bus_addr_i == REG_MASK);
  assign wr_prio  = bus_we_i && (bus_addr_i == REG_PRIO);

  assign gie   = mask_q[GIE_BIT];
  assign pend  = req_q & mask_q[NUM_IRQ-1:0] & {NUM_IRQ{gie}};
  assign grant = irq_ack_i && irq_req_o;

  irq_prio_sel #(.N(NUM_IRQ), .IDW(IRQ_IDW), .CODE_W(PRIO_W)) u_prio (
    .pend_i  (pend),
    .code_i  (prio_q),
    .valid_o (irq_req_o),
    .id_o    (irq_id_o)
  );

  always_comb begin
    ack_clr = '0;
    if (grant) ack_clr[irq_id_o] = 1'b1;
  end

  // software write beats ack; source events beat both
  always_comb begin
    if (wr_flags) req_d = bus_wdata_i[NUM_IRQ-1:0];
    else          req_d = req_q & ~ack_clr;
    req_d = req_d | edge_set;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= '0;
      mask_q <= '0;
      prio_q <= '0;
    end else begin
      req_q <= req_d;
      if (wr_mask)    mask_q <= bus_wdata_i;
      else if (grant) mask_q[GIE_BIT] <= 1'b0;
      if (wr_prio)    prio_q <= bus_wdata_i[PRIO_W-1:0];
    end
  end

  always_comb begin
    unique case (bus_addr_i)
      REG_FLAGS: bus_rdata_o = DATA_W'(req_q);
      REG_MASK:  bus_rdata_o = mask_q;
      REG_PRIO:  bus_rdata_o = DATA_W'(prio_q);
      default:   bus_rdata_o = '0;
    endcase
  end

  assign vec_lo_o = VEC_W'(irq_id_o) << 1;
  assign vec_hi_o = vec_lo_o | VEC_W'(1);

  // R4
  tmr0_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr0_pulse_i |=> req_q[4]);
  // R4
  tmr1_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr1_pulse_i |=> req_q[5]);
  // R6
  req_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> (gie && req_q[irq_id_o] && mask_q[irq_id_o]));
  // R9
  gie_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && irq_req_o && !wr_mask) |=> !mask_q[GIE_BIT]);
  // R9
  flag_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && irq_req_o && !wr_flags && !edge_set[irq_id_o]) |=> !req_q[$past(irq_id_o)]);
  // R12
  idle_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && !irq_req_o && !bus_we_i) |=> $stable(mask_q));
endmodule

// File: tb/vec_irq_ctrl_tb.sv
`timescale 1ns/1ps
module vec_irq_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pin_a = 1'b1, pin_b = 1'b1, pin_c = 1'b1;
  logic t0 = 1'b0, t1 = 1'b0, we = 1'b0, ack = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic req;
  logic [2:0] id;
  logic [7:0] vlo, vhi;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  vec_irq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_a_i(pin_a), .pin_b_i(pin_b), .pin_c_i(pin_c),
    .tmr0_pulse_i(t0), .tmr1_pulse_i(t1), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_we_i(we), .bus_rdata_o(rdata), .irq_ack_i(ack), .irq_req_o(req),
    .irq_id_o(id), .vec_lo_o(vlo), .vec_hi_o(vhi)
  );

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd(logic [1:0] a, int exp, string tag);
    addr = a;
    #0.5;
    check(tag, rdata, exp);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic pin_wait();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    rd(2'd0, 0, "R1 flags");
    rd(2'd1, 0, "R1 mask");
    rd(2'd2, 0, "R1 prio");
    check("R1 req", req, 0);
  endtask

  task automatic t_pins();
    @(negedge clk); pin_b = 1'b0; pin_wait();
    rd(2'd0, 8'h01, "R2 pin B fall sets flag0, R3 no flag3");
    wr(2'd0, 8'h00);
    @(negedge clk); pin_b = 1'b1; pin_wait();
    rd(2'd0, 8'h08, "R3 pin B rise sets flag3");
    wr(2'd0, 8'h00);
    @(negedge clk); pin_c = 1'b0; pin_wait();
    rd(2'd0, 8'h02, "R2 pin C fall sets flag1");
    @(negedge clk); pin_a = 1'b0; pin_wait();
    rd(2'd0, 8'h06, "R5 pin A flag2 latched while masked");
    check("R6 masked no req", req, 0);
    @(negedge clk); pin_a = 1'b1; pin_c = 1'b1; pin_wait();
    rd(2'd0, 8'h06, "R2 rises on A and C set nothing");
    wr(2'd0, 8'h00);
  endtask

  task automatic t_timers();
    @(negedge clk); t0 = 1'b1;
    @(negedge clk); t0 = 1'b0;
    rd(2'd0, 8'h10, "R4 timer0 flag4");
    @(negedge clk); t1 = 1'b1;
    @(negedge clk); t1 = 1'b0;
    rd(2'd0, 8'h30, "R4 timer1 flag5");
    wr(2'd0, 8'h00);
  endtask

  task automatic t_mask();
    wr(2'd0, 8'h3F);
    rd(2'd0, 8'h3F, "R11 write sets flags");
    wr(2'd1, 8'hC4);
    rd(2'd1, 8'hC4, "R6 mask readback");
    check("R6 req enabled", req, 1);
    check("R6 id", id, 2);
    wr(2'd1, 8'h44);
    check("R6 gie off no req", req, 0);
    wr(2'd1, 8'h3F);
    check("R6 enables without gie", req, 0);
  endtask

  task automatic t_prio();
    wr(2'd1, 8'hBF);
    for (int c = 0; c < 8; c++) begin
      wr(2'd2, 8'(c));
      check("R7 full set", id, (c < 6) ? c : 0);
    end
    wr(2'd0, 8'h24);
    wr(2'd2, 8'd3);
    check("R7 wrap code3", id, 5);
    check("R8 vec lo", vlo, 10);
    check("R8 vec hi", vhi, 11);
    wr(2'd2, 8'd7);
    check("R7 code7 ascending", id, 2);
    check("R8 vec lo id2", vlo, 4);
    check("R8 vec hi id2", vhi, 5);
  endtask

  task automatic t_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    rd(2'd0, 8'h20, "R9 granted flag cleared");
    rd(2'd1, 8'h3F, "R9 gie cleared");
    check("R9 req low", req, 0);
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    rd(2'd0, 8'h20, "R12 idle ack flags");
    rd(2'd1, 8'h3F, "R12 idle ack mask");
  endtask

  task automatic t_race();
    wr(2'd0, 8'h10);
    wr(2'd1, 8'hBF);
    check("R10 setup id4", id, 4);
    @(negedge clk); ack = 1'b1; t0 = 1'b1;
    @(negedge clk); ack = 1'b0; t0 = 1'b0;
    rd(2'd0, 8'h10, "R10 event beats clear");
    rd(2'd1, 8'h3F, "R10 gie dropped");
    wr(2'd0, 8'h00);
    rd(2'd0, 8'h00, "R11 write clears flags");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    repeat (5) @(negedge clk);
    t_pins();
    t_timers();
    t_mask();
    t_prio();
    t_ack();
    t_race();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #40000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule